// File: doc/BRIEF.md
# UTOPIA Level 2 Multi-PHY Cell Input Port

This block is the PHY-side receiver of a UTOPIA Level 1/Level 2 transmit bus using cell-level handshake. An ATM-layer master polls PHY addresses on a shared 5-bit address bus. The block answers each poll one clock later on a cell-available line. That line is driven only when the polled address belongs to one of its enabled address entries; otherwise its output enable is dropped so other PHYs on the bus can answer.

Each address entry is a buffer target with a one-cell occupancy flag. A cell is selected by the address seen in the cycle before the active-low enable falls. It starts with SOC and is forwarded as a stream of write strobes: 53 bytes in 8-bit mode or 27 words in 16-bit mode. A downstream consumer frees the entry with a release pulse. Parity is checked on every written word against a selectable odd/even sense. Any mismatch raises a sticky error flag, and the cell is still accepted.

Top module: `utopia_cell_in`

## Requirements
- R1: With `WIDE`=1 the data bus is 16 bits and a cell is 27 transfers; with `WIDE`=0 it is 8 bits and 53 transfers. An accepted cell produces exactly that many `wr_en` pulses, the first marked by `wr_first`, all with `wr_port` equal to the selected entry and `wr_data` equal to the transferred words in order.
- R2: Entry i (address field `cfg_addr[5i+4:5i]`, enable `cfg_en[i]`) matches an address when enabled and equal to it. Address 31 never matches. When several entries match, the lowest index wins.
- R3: The address on `phy_addr` at a rising edge sets `clav_oe` and `clav` after that edge. On a match, `clav_oe`=1 and `clav` = 1 when the matched entry is empty. With no match, `clav_oe`=0 and `clav`=0.
- R4: The entry is selected by the address sampled in the cycle before `enb_n` goes from 1 to 0. The selection holds while `enb_n` stays low.
- R5: A cell starts only on a cycle with `enb_n`=0, `soc`=1, no cell in progress and a matching selection. Words with `enb_n`=0 outside a cell and without SOC are discarded.
- R6: SOC during the remainder of a cell is ignored. The cell keeps its length and its target.
- R7: Only cycles with `enb_n`=0 transfer data. Cycles with `enb_n`=1 pause a cell without writes, and a cell keeps its target across such pauses.
- R8: With `odd_par`=1 the ones in {`data`,`par`} must be odd; with `odd_par`=0 they must be even. A mismatch on a written word sets `par_err`, which stays 1 until reset. The cell is still written and completed.
- R9: An entry becomes occupied on the last word of its cell, and `rel_en` with `rel_idx` frees it. A cell aimed at an occupied entry is consumed to its full length without any write and leaves the entry occupied.
- R10: After reset no entry is occupied, `par_err`=0, `wr_en`=0 and `clav_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTOPIA interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 5*NPORT | PHY address of each entry, 5 bits per entry |
| cfg_en | input | NPORT | Enable of each entry |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even |
| phy_addr | input | 5 | Polling/selection address bus |
| enb_n | input | 1 | Active-low transfer enable |
| soc | input | 1 | Start of cell marker |
| data | input | DW | Cell data, 16 or 8 bits |
| par | input | 1 | Parity bit over `data` |
| rel_en | input | 1 | Release pulse for one entry |
| rel_idx | input | IW | Entry freed by `rel_en` |
| clav | output | 1 | Cell-available answer to the previous poll |
| clav_oe | output | 1 | Output enable of `clav` (0 means high impedance) |
| wr_en | output | 1 | Buffer write strobe |
| wr_first | output | 1 | Write strobe carries the first word of a cell |
| wr_port | output | IW | Entry written |
| wr_data | output | DW | Word written |
| par_err | output | 1 | Sticky parity error |

## Verification
The assertions take for granted that the master obeys the bus rules. Address 31 is placed on the bus whenever the master does not mean to poll. `enb_n` is only lowered after a valid address cycle, and configuration changes only while no cell is in progress. The stimulus keeps to these rules. Every cell is sent from an idle bus with a fresh address cycle, and pauses put address 31 on the bus. Configuration and parity sense change only between cells. Random polls and random pause patterns then run inside these limits.

// File: rtl/utopia_cell_in.sv
module utopia_cell_in #(
  parameter int NPORT = 4,
  parameter bit WIDE = 1'b1,
  localparam int DW = WIDE ? 16 : 8,
  localparam int CELL_WORDS = WIDE ? 27 : 53,
  localparam int CW = $clog2(CELL_WORDS),
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT*5-1:0] cfg_addr,
  input  logic [NPORT-1:0]   cfg_en,
  input  logic               odd_par,
  input  logic [4:0]         phy_addr,
  input  logic               enb_n,
  input  logic               soc,
  input  logic [DW-1:0]      data,
  input  logic               par,
  input  logic               rel_en,
  input  logic [IW-1:0]      rel_idx,
  output logic               clav,
  output logic               clav_oe,
  output logic               wr_en,
  output logic               wr_first,
  output logic [IW-1:0]      wr_port,
  output logic [DW-1:0]      wr_data,
  output logic               par_err
);

  function automatic logic [IW:0] lookup(input logic [4:0] a);
    lookup = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (cfg_en[i] && cfg_addr[i*5 +: 5] == a && a != 5'd31)
        lookup = {1'b1, IW'(i)};
  endfunction

  logic [4:0]       addr_q;
  logic             enb_q;
  logic             sel_hit_q;
  logic [IW-1:0]    sel_idx_q;
  logic             busy, drop;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    port;
  logic [NPORT-1:0] occ;
  logic [NPORT-1:0] rel_mask, set_mask;
  logic [IW:0]      poll_lk, sel_lk;

  assign poll_lk = lookup(phy_addr);
  assign sel_lk  = lookup(addr_q);

  wire          fall    = enb_q & ~enb_n;
  wire          sel_hit = fall ? sel_lk[IW] : sel_hit_q;
  wire [IW-1:0] sel_idx = fall ? sel_lk[IW-1:0] : sel_idx_q;
  wire          take    = ~enb_n;
  wire          start   = take & soc & ~busy & sel_hit;
  wire          cont    = take & busy;
  wire          last    = cont & (cnt == CW'(CELL_WORDS - 1));
  wire          wr_now  = (start & ~occ[sel_idx]) | (cont & ~drop);
  wire          par_bad = (^{data, par}) != odd_par;

  always_comb begin
    rel_mask = '0;
    set_mask = '0;
    if (rel_en) rel_mask[rel_idx] = 1'b1;
    if (last && !drop) set_mask[port] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= 5'd31;
      enb_q     <= 1'b1;
      sel_hit_q <= 1'b0;
      sel_idx_q <= '0;
      busy      <= 1'b0;
      drop      <= 1'b0;
      cnt       <= '0;
      port      <= '0;
      occ       <= '0;
      clav      <= 1'b0;
      clav_oe   <= 1'b0;
      wr_en     <= 1'b0;
      wr_first  <= 1'b0;
      wr_port   <= '0;
      wr_data   <= '0;
      par_err   <= 1'b0;
    end else begin
      addr_q <= phy_addr;
      enb_q  <= enb_n;
      if (fall) begin
        sel_hit_q <= sel_lk[IW];
        sel_idx_q <= sel_lk[IW-1:0];
      end
      if (start) begin
        busy <= 1'b1;
        drop <= occ[sel_idx];
        port <= sel_idx;
        cnt  <= CW'(1);
      end else if (cont) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
      occ      <= (occ & ~rel_mask) | set_mask;
      clav_oe  <= poll_lk[IW];
      clav     <= poll_lk[IW] & ~occ[poll_lk[IW-1:0]];
      wr_en    <= wr_now;
      wr_first <= start & ~occ[sel_idx];
      wr_port  <= start ? sel_idx : port;
      wr_data  <= data;
      if (wr_now && par_bad) par_err <= 1'b1;
    end
  end

endmodule

// File: rtl/utopia_cell_in_chk.sv
module utopia_cell_in_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] phy_addr,
  input logic       enb_n,
  input logic       soc,
  input logic       clav,
  input logic       clav_oe,
  input logic       wr_en,
  input logic       wr_first,
  input logic       par_err
);

  AST_RESERVED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_addr == 5'd31) |=> !clav_oe); // R2

  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !clav_oe |-> !clav); // R3

  AST_FIRST_NEEDS_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    !(soc && !enb_n) |=> !wr_first); // R5

  AST_NO_WRITE_ON_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    enb_n |=> !wr_en); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err); // R8

endmodule

bind utopia_cell_in utopia_cell_in_chk u_chk (.*);

// File: tb/utopia_cell_in_test.sv
module utopia_cell_in_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 4;
  localparam bit WIDE = 1'b1;
  localparam int DW = WIDE ? 16 : 8;
  localparam int CELL = WIDE ? 27 : 53;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic [NPORT*5-1:0] cfg_addr;
  logic [NPORT-1:0] cfg_en;
  logic odd_par = 1, enb_n = 1, soc = 0, par = 0, rel_en = 0;
  logic [4:0] phy_addr = 5'd31;
  logic [DW-1:0] data = '0;
  logic [IW-1:0] rel_idx = '0;
  logic clav, clav_oe, wr_en, wr_first, par_err;
  logic [IW-1:0] wr_port;
  logic [DW-1:0] wr_data;

  utopia_cell_in #(.NPORT(NPORT), .WIDE(WIDE)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int wr_seen = 0, wr_bad = 0, first_seen = 0, exp_port = 0;
  logic [DW-1:0] exp_q[$];
  logic [4:0] m_addr[NPORT];
  bit m_en[NPORT], m_occ[NPORT];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic gpar(input logic [DW-1:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  function automatic int mlook(input logic [4:0] a);
    for (int i = 0; i < NPORT; i++)
      if (m_en[i] && m_addr[i] == a && a != 5'd31) return i;
    return -1;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < NPORT; i++) begin
      cfg_addr[i*5 +: 5] = m_addr[i];
      cfg_en[i] = m_en[i];
    end
  endtask

  always @(negedge clk) if (rst_n && wr_en) begin
    wr_seen++;
    if (wr_first) first_seen++;
    if (exp_q.size() == 0) wr_bad++;
    else begin
      if (wr_data != exp_q[0] || int'(wr_port) != exp_port) wr_bad++;
      void'(exp_q.pop_front());
    end
  end

  task automatic clear_mon();
    wr_seen = 0; wr_bad = 0; first_seen = 0; exp_q.delete();
  endtask

  task automatic send_cell(input logic [4:0] a, input bit wr_exp, input bit gaps,
                           input bit mid_soc, input bit bad_par);
    @(negedge clk); phy_addr = a; enb_n = 1; soc = 0;
    for (int i = 0; i < CELL; i++) begin
      logic [DW-1:0] d;
      if (gaps && i > 0 && ($urandom % 4 == 0)) begin
        @(negedge clk); enb_n = 1; soc = 0; phy_addr = 5'd31;
      end
      @(negedge clk);
      enb_n = 0; phy_addr = 5'd31;
      soc = (i == 0) || (mid_soc && (i == 10 || i == CELL - 1));
      d = DW'($urandom);
      data = d;
      par = gpar(d, odd_par) ^ (bad_par && i == 5);
      if (wr_exp) exp_q.push_back(d);
    end
    @(negedge clk); enb_n = 1; soc = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic poll(input logic [4:0] a, output bit oe, output bit cv);
    @(negedge clk); phy_addr = a; enb_n = 1;
    @(negedge clk); oe = clav_oe; cv = clav; phy_addr = 5'd31;
  endtask

  task automatic poll_check(input logic [4:0] a, input string req);
    bit oe, cv;
    int idx;
    bit eoe, ecv;
    idx = mlook(a);
    eoe = idx >= 0;
    ecv = eoe && !m_occ[idx];
    poll(a, oe, cv);
    chk(oe == eoe, req, oe, eoe);
    chk(cv == ecv, req, cv, ecv);
  endtask

  task automatic release_entry(input int i);
    @(negedge clk); rel_en = 1; rel_idx = IW'(i);
    @(negedge clk); rel_en = 0;
    m_occ[i] = 0;
  endtask

  task automatic cell_check(input logic [4:0] a, input bit gaps, input bit mid_soc,
                            input bit bad_par, input string req);
    int idx;
    bit wr_exp;
    idx = mlook(a);
    wr_exp = (idx >= 0) && !m_occ[idx];
    exp_port = idx;
    clear_mon();
    send_cell(a, wr_exp, gaps, mid_soc, bad_par);
    chk(wr_seen == (wr_exp ? CELL : 0), req, wr_seen, wr_exp ? CELL : 0);
    chk(wr_bad == 0, req, wr_bad, 0);
    chk(first_seen == (wr_exp ? 1 : 0), req, first_seen, wr_exp ? 1 : 0);
    if (wr_exp) m_occ[idx] = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_addr[0] = 5'd5;  m_en[0] = 1;
    m_addr[1] = 5'd9;  m_en[1] = 1;
    m_addr[2] = 5'd31; m_en[2] = 1;
    m_addr[3] = 5'd12; m_en[3] = 0;
    for (int i = 0; i < NPORT; i++) m_occ[i] = 0;
    apply_cfg();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(clav_oe == 0, "R10", clav_oe, 0);
    chk(wr_en == 0, "R10", wr_en, 0);
    chk(par_err == 0, "R10", par_err, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(clav_oe == 0, "R10", clav_oe, 0);
    poll_check(5'd5, "R3");
    poll_check(5'd31, "R2");
    poll_check(5'd12, "R2");
    poll_check(5'd7, "R3");

    // R5 words without SOC are dropped
    clear_mon();
    @(negedge clk); phy_addr = 5'd5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); enb_n = 0; phy_addr = 5'd31; soc = 0; data = DW'($urandom);
    end
    @(negedge clk); enb_n = 1;
    repeat (2) @(negedge clk);
    chk(wr_seen == 0, "R5", wr_seen, 0);

    // R1 plain cell, odd parity
    odd_par = 1;
    cell_check(5'd5, 0, 0, 0, "R1");
    poll_check(5'd5, "R9");
    // R6 R7 cell with pauses and stray SOC, even parity
    odd_par = 0;
    cell_check(5'd9, 1, 1, 0, "R6");
    poll_check(5'd9, "R9");
    chk(par_err == 0, "R8", par_err, 0);
    // R9 cell to an occupied entry is consumed without writes
    cell_check(5'd5, 0, 0, 0, "R9");
    poll_check(5'd5, "R9");
    // R5 cell to an unmatched address
    cell_check(5'd7, 0, 0, 0, "R5");
    release_entry(0);
    poll_check(5'd5, "R9");

    // R8 bad parity: cell still accepted, flag sticky
    odd_par = 1;
    cell_check(5'd5, 1, 0, 1, "R8");
    chk(par_err == 1, "R8", par_err, 1);
    release_entry(0);
    cell_check(5'd5, 0, 0, 0, "R8");
    chk(par_err == 1, "R8", par_err, 1);

    // R2 priority, R4 selection
    m_addr[3] = 5'd9; m_en[3] = 1; apply_cfg();
    poll_check(5'd9, "R2");
    m_en[1] = 0; apply_cfg();
    poll_check(5'd9, "R2");
    cell_check(5'd9, 1, 0, 0, "R4");
    poll_check(5'd9, "R4");

    // random phase
    for (int n = 0; n < 12; n++) begin
      logic [4:0] a;
      int r;
      r = int'($urandom % 3);
      a = (r == 0) ? 5'd5 : (r == 1) ? 5'd9 : 5'(($urandom % 32));
      if ($urandom % 2 == 0) release_entry(int'($urandom % NPORT));
      cell_check(a, bit'($urandom % 2), bit'($urandom % 2), 0, "R7");
    end
    for (int n = 0; n < 150; n++) begin
      if ($urandom % 8 == 0) release_entry(int'($urandom % NPORT));
      poll_check(5'($urandom % 32), "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule